// File: doc/BRIEF.md
# Latched Fault Interrupt Status Register

This block gathers supervisory warning and fault events for a power-management device. It reports them through an 8-bit read-only status register and an active-low interrupt line. There are five sources: a power-good timeout, an input-undervoltage warning, an input-undervoltage fault, a thermal warning and a thermal fault. Each source owns one fixed bit. A bit latches as soon as its event is seen and stays latched after the event ends. It drops only when the host issues a one-cycle clear strobe at a time when that source is inactive.

The two fault-class sources, undervoltage fault and thermal fault, also raise a one-cycle shutdown request. The request fires when such a condition first becomes active. While every regulator is off, the undervoltage and thermal inputs are masked, so the sensors may float or power down without causing events. The serial-bus decoder that reads the register and produces the clear strobe lies outside this block, and so do the analog comparators.

Top module: `fault_irq_status`

## Requirements
- R1: Bit positions are fixed: bit 3 is the power-good timeout, bit 4 the undervoltage warning, bit 5 the undervoltage fault, bit 6 the thermal warning and bit 7 the thermal fault. Bits 2..0 always read 0.
- R2: When a source is active, its status bit is 1 after the next rising clock edge.
- R3: A status bit that is set stays set after its source goes inactive, for as long as no clear strobe arrives.
- R4: A clear strobe clears, at the next edge, every set bit whose source is inactive in the strobe cycle.
- R5: If a source is active in the same cycle as a clear strobe, its bit stays set. The event takes priority over the clear.
- R6: irqN is 0 exactly when at least one status bit is 1, in the same cycle as the register value.
- R7: While allRegOff is high (no regulator enabled), the undervoltage and thermal inputs have no effect. The power-good timeout input is not masked.
- R8: shutdownReq is high for one cycle, one edge after the (unmasked) undervoltage fault or thermal fault becomes active. It pulses once even when both rise together. Warnings and the power-good timeout never raise it.
- R9: While rstN is low, the status register is 0, irqN is 1 and shutdownReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pgTimeout | input | 1 | Power-good timeout condition |
| uvWarn | input | 1 | Input-undervoltage warning condition |
| uvFault | input | 1 | Input-undervoltage fault condition |
| thWarn | input | 1 | Thermal warning condition |
| thFault | input | 1 | Thermal fault condition |
| allRegOff | input | 1 | High when every regulator is disabled |
| clearCmd | input | 1 | One-cycle clear-interrupt strobe |
| statusReg | output | 8 | Latched status bits |
| irqN | output | 1 | Active-low interrupt |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
The stimulus table runs through several sequences, each aimed at a different ambiguity:
- A warning that comes and goes, followed by a clear, separates a latch from a level follower.
- A clear that arrives while a fault is still present, and a clear that lands on one live bit and one dead bit, show that the clear acts per bit and that a live event wins over the clear.
- Driving every sensor while the regulators are off, with the power-good timeout alone still taking effect, shows which inputs the regulator-off mask covers.
- A fault that is held, masked and then unmasked, plus a case where both faults rise together, tells edge-triggered shutdown from level-triggered shutdown and shows that the request stays a single pulse.

// File: rtl/fisr_pkg.sv
package fisr_pkg;
  // Number of event sources held in the status register.
  localparam int SRC_N = 5;

  // Source index order; status bit = base bit + index.
  localparam int SRC_PG  = 0;
  localparam int SRC_UVW = 1;
  localparam int SRC_UVF = 2;
  localparam int SRC_THW = 3;
  localparam int SRC_THF = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [SRC_N-1:0] setVec;  // sources active this cycle (after masking)
    logic             clr;     // clear strobe
  } fisrStrobe_t;
endpackage

// File: rtl/fisr_ctrl.sv
module fisr_ctrl
  import fisr_pkg::*;
#(
  parameter logic [SRC_N-1:0] GATED_MASK = 5'b11110,
  parameter logic [SRC_N-1:0] FAULT_MASK = 5'b10100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] rawEvt,
  input  logic             allRegOff,
  input  logic             clearCmd,
  output fisrStrobe_t      strobe,
  output logic             shutdownReq
);
  logic [SRC_N-1:0] condNow;
  logic [SRC_N-1:0] faultNow;
  logic [SRC_N-1:0] faultPrev;
  logic             shotQ;

  // Masked sources are forced inactive while every regulator is off.
  always_comb begin
    condNow  = rawEvt & ~(GATED_MASK & {SRC_N{allRegOff}});
    faultNow = condNow & FAULT_MASK;
  end

  always_comb begin
    strobe.setVec = condNow;
    strobe.clr    = clearCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPrev <= '0;
      shotQ     <= 1'b0;
    end else begin
      faultPrev <= faultNow;
      shotQ     <= |(faultNow & ~faultPrev);
    end
  end

  assign shutdownReq = shotQ;

  // R8: a shutdown pulse needs a fault-class input in the previous cycle
  p_shot_has_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    shotQ |-> $past(|(rawEvt & FAULT_MASK)));

  // R8: a fault held steady with the mask unchanged gives no second pulse
  p_shot_no_repeat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (shotQ && $stable(rawEvt) && $stable(allRegOff)) |=> !shotQ);
endmodule

// File: rtl/fisr_dp.sv
module fisr_dp
  import fisr_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int BASE_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fisrStrobe_t       strobe,
  output logic [STAT_W-1:0] statusReg,
  output logic              irqN
);
  localparam int TOP_BIT = BASE_BIT + SRC_N - 1;

  logic [SRC_N-1:0] bitQ;

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    // An active event wins over the clear strobe.
    always_ff @(posedge clk) begin
      if (!rstN)                  bitQ[i] <= 1'b0;
      else if (strobe.setVec[i])  bitQ[i] <= 1'b1;
      else if (strobe.clr)        bitQ[i] <= 1'b0;
    end

    // R2: an active source is latched at the next edge
    p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setVec[i] |=> bitQ[i]);
    // R3: without a clear strobe a set bit stays set
    p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (bitQ[i] && !strobe.clr) |=> bitQ[i]);
    // R4: a clear with the source inactive drops the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clr && !strobe.setVec[i]) |=> !bitQ[i]);
    // R5: a clear during an active event leaves the bit set
    p_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clr && strobe.setVec[i]) |=> bitQ[i]);
  end

  always_comb begin
    statusReg = '0;
    statusReg[TOP_BIT:BASE_BIT] = bitQ;
  end

  assign irqN = ~|bitQ;
endmodule

// File: rtl/fault_irq_status.sv
module fault_irq_status
  import fisr_pkg::*;
#(
  parameter int               STAT_W     = 8,
  parameter int               BASE_BIT   = 3,
  parameter logic [SRC_N-1:0] GATED_MASK = 5'b11110,
  parameter logic [SRC_N-1:0] FAULT_MASK = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgTimeout,
  input  logic              uvWarn,
  input  logic              uvFault,
  input  logic              thWarn,
  input  logic              thFault,
  input  logic              allRegOff,
  input  logic              clearCmd,
  output logic [STAT_W-1:0] statusReg,
  output logic              irqN,
  output logic              shutdownReq
);
  logic [SRC_N-1:0] rawEvt;
  fisrStrobe_t      strobe;

  always_comb begin
    rawEvt          = '0;
    rawEvt[SRC_PG]  = pgTimeout;
    rawEvt[SRC_UVW] = uvWarn;
    rawEvt[SRC_UVF] = uvFault;
    rawEvt[SRC_THW] = thWarn;
    rawEvt[SRC_THF] = thFault;
  end

  fisr_ctrl #(
    .GATED_MASK(GATED_MASK),
    .FAULT_MASK(FAULT_MASK)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rawEvt     (rawEvt),
    .allRegOff  (allRegOff),
    .clearCmd   (clearCmd),
    .strobe     (strobe),
    .shutdownReq(shutdownReq)
  );

  fisr_dp #(
    .STAT_W  (STAT_W),
    .BASE_BIT(BASE_BIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .statusReg(statusReg),
    .irqN     (irqN)
  );

  // R7: with regulators off, a clear thermal-warning bit stays clear
  p_gate_thw_r7: assert property (@(posedge clk) disable iff (!rstN)
    (allRegOff && !statusReg[BASE_BIT+SRC_THW]) |=> !statusReg[BASE_BIT+SRC_THW]);
  // R7: the power-good timeout still latches with regulators off
  p_pg_ungated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (allRegOff && pgTimeout) |=> statusReg[BASE_BIT+SRC_PG]);
  // R8: warnings alone never request shutdown
  p_warn_no_shot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!uvFault && !thFault) |=> !shutdownReq);
endmodule

// File: tb/fault_irq_status_tb_top.sv
module fault_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       pgTimeout, uvWarn, uvFault, thWarn, thFault;
  logic       allRegOff, clearCmd;
  logic [7:0] statusReg;
  logic       irqN, shutdownReq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  fault_irq_status dut_i (
    .clk(clk), .rstN(rstN),
    .pgTimeout(pgTimeout), .uvWarn(uvWarn), .uvFault(uvFault),
    .thWarn(thWarn), .thFault(thFault),
    .allRegOff(allRegOff), .clearCmd(clearCmd),
    .statusReg(statusReg), .irqN(irqN), .shutdownReq(shutdownReq)
  );

  // Row: {off, clr, thF, thW, uvF, uvW, pg, expStatus[7:0], expShutdown}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'b00010, 8'h10, 1'b0},  // R2 undervoltage warning latches
    {1'b0, 1'b0, 5'b00000, 8'h10, 1'b0},  // R3 held after source ends
    {1'b0, 1'b1, 5'b00000, 8'h00, 1'b0},  // R4 clear with source gone
    {1'b0, 1'b0, 5'b00100, 8'h20, 1'b1},  // R8 undervoltage fault pulse
    {1'b0, 1'b0, 5'b00100, 8'h20, 1'b0},  // R8 no repeat while held
    {1'b0, 1'b1, 5'b00100, 8'h20, 1'b0},  // R5 clear while active
    {1'b0, 1'b0, 5'b01000, 8'h60, 1'b0},  // R2 thermal warning adds
    {1'b0, 1'b1, 5'b01000, 8'h40, 1'b0},  // R4 R5 per-bit clear
    {1'b0, 1'b1, 5'b00000, 8'h00, 1'b0},  // R4 clear rest
    {1'b1, 1'b0, 5'b11110, 8'h00, 1'b0},  // R7 sensors masked
    {1'b1, 1'b0, 5'b00001, 8'h08, 1'b0},  // R7 pg timeout not masked
    {1'b0, 1'b0, 5'b10000, 8'h88, 1'b1},  // R8 thermal fault pulse
    {1'b0, 1'b1, 5'b10000, 8'h80, 1'b0},  // R5 fault wins, pg cleared
    {1'b1, 1'b1, 5'b10000, 8'h00, 1'b0},  // R7 masked fault clears
    {1'b0, 1'b0, 5'b10000, 8'h80, 1'b1},  // R8 unmask gives new rise
    {1'b0, 1'b1, 5'b00000, 8'h00, 1'b0}   // R4 final clear
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    allRegOff = v[6];
    clearCmd  = v[5];
    thFault   = v[4];
    thWarn    = v[3];
    uvFault   = v[2];
    uvWarn    = v[1];
    pgTimeout = v[0];
  endtask

  // Drive at the falling edge, check after the next falling edge.
  task automatic step_check(input logic [6:0] v, input logic [7:0] expS,
                            input logic expSh);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    check("R2 R3 R4 R5 R7 status", int'(statusReg), int'(expS));
    check("R1 low bits zero", int'(statusReg[2:0]), 0);
    check("R6 irqN", int'(irqN), int'(expS == 8'h00));
    check("R8 shutdownReq", int'(shutdownReq), int'(expSh));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(7'b0);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset status", int'(statusReg), 0);
    check("R9 reset irqN", int'(irqN), 1);
    check("R9 reset shutdownReq", int'(shutdownReq), 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++)
      step_check(VEC[k][15:9], VEC[k][8:1], VEC[k][0]);

    // R1 R8: every source at once, one pulse for two rising faults
    step_check(7'b0011111, 8'hF8, 1'b1);
    step_check(7'b0011111, 8'hF8, 1'b0);
    // R5: clear with everything still active keeps all bits
    step_check(7'b0111111, 8'hF8, 1'b0);
    // R8: faults drop and return while bits stay latched -> new pulse
    step_check(7'b0000000, 8'hF8, 1'b0);
    step_check(7'b0000100, 8'hF8, 1'b1);

    // R9: reset mid-run wipes latched bits
    @(negedge clk);
    drive(7'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 mid reset status", int'(statusReg), 0);
    check("R9 mid reset irqN", int'(irqN), 1);
    check("R9 mid reset shutdownReq", int'(shutdownReq), 0);
    rstN = 1'b1;
    step_check(7'b0000000, 8'h00, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule